// File: doc/BRIEF.md
# Proportional Two-List Interleave Merger

The block holds two slot lists, A and B, each with a fixed number of positions. Every position holds either a device index or the all-ones empty marker. When started, the block merges the two lists into one output stream. The entries of the shorter list are spread evenly among the entries of the longer list. A signed credit counter paces the merge: each pop from the short list adds a fixed scale of 100000 to the counter, and each pop from the long list subtracts a target score. That score is the short length times 100000, divided by the long length.

Software, or a neighbouring engine, fills the lists through the load ports and pulses `start`. It then collects one output word per `outWrEn` cycle. `done` marks the end of the merge. `error` marks a merge that stalled.

A serial restoring divider computes the target score. It takes 17 cycles after `start`. After that, the block moves at most one entry per cycle.

Top module: `interleave_merger`

## Requirements
- R1: A position whose value is 16'hFFFF is empty, and a list's length is the number of other positions. An empty position is never written to the output.
- R2: Every pop takes the non-empty position with the lowest index and overwrites it with 16'hFFFF. After a merge that ends without error, both lists are therefore empty, and a second `start` with no new loads completes with no output writes.
- R3: If list B holds more entries than list A, then A is the short list and B is the long list. Otherwise B is the short list and A is the long list.
- R4: The target score is floor(100000 × short length / long length).
- R5: A round first pops one short-list entry, if there is one, and adds 100000 to the counter. It then pops long-list entries, subtracting the target score after each, for as long as the long list is non-empty and the counter is above zero. Entries reach the output in pop order.
- R6: Rounds repeat until both lists are empty. The block then raises `done` with `error` low. A round that moves no entry raises `done` and `error` together, and no further output is written.
- R7: Output writes carry consecutive indices that start at 0 for each merge.
- R8: After reset, `done`, `error` and `outWrEn` are low and both lists are empty.
- R9: `done` and `error` hold their values until the next `start`.
- R10: A `start` with both lists empty raises `done` within two cycles, with `error` low and no output write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadA | input | 1 | Write `loadData` into list A at `loadIdx` (ignored while merging) |
| loadB | input | 1 | Write `loadData` into list B at `loadIdx` (ignored while merging) |
| loadIdx | input | IDX_W | Position to load |
| loadData | input | DATA_W | Entry value, or 16'hFFFF for empty |
| start | input | 1 | Begin a merge (ignored while merging) |
| outWrEn | output | 1 | Output word valid this cycle |
| outIdx | output | OUT_W | Output position |
| outData | output | DATA_W | Output entry |
| done | output | 1 | Merge finished |
| error | output | 1 | Merge stalled |

## Verification
The stall is the hardest case to reach. It only occurs when the short list is empty while the long list still holds entries and the counter is not positive. From the ports, this means loading exactly one list and leaving the other empty. It also means leaving behind the remains of a stalled run, which a second start must stall on again.

The bench sweeps every pair of lengths on a small list depth. It scatters entries over different positions so that lowest-index popping matters. For each pair it runs the merge twice. The second run shows that successful pops emptied the lists, and that stalled lists were left untouched.

// File: rtl/interleave_merger_pkg.sv
package interleave_merger_pkg;

  typedef struct packed {
    logic initRun;
    logic divStep;
    logic popShort;
    logic popLong;
  } mergeStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_ROUND,
    ST_LONG,
    ST_DONE,
    ST_ERR
  } mergeState_t;

endpackage

// File: rtl/interleave_merger_dp.sv
module interleave_merger_dp
  import interleave_merger_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  parameter int SCALE  = 100000,
  parameter int QUOT_W = 17,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int OUT_W = $clog2(2 * DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              loadA,
  input  logic              loadB,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [DATA_W-1:0] loadData,
  input  mergeStrobes_t     strb,
  output logic              shortEmpty,
  output logic              longEmpty,
  output logic              bothEmpty,
  output logic              cntPos,
  output logic              divLast,
  output logic              outWrEn,
  output logic [OUT_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outData
);

  localparam int NUM_W  = QUOT_W + LEN_W;
  localparam int DCNT_W = $clog2(QUOT_W + 1);
  localparam logic [DATA_W-1:0] EMPTY = '1;

  logic [DATA_W-1:0] listA [DEPTH];
  logic [DATA_W-1:0] listB [DEPTH];
  logic [DEPTH-1:0]  liveA, liveB;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_live
      assign liveA[g] = (listA[g] != EMPTY);
      assign liveB[g] = (listB[g] != EMPTY);
    end
  endgenerate

  function automatic logic [IDX_W-1:0] lowestSet(input logic [DEPTH-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [IDX_W-1:0] firstA, firstB;
  logic [LEN_W-1:0] lenA, lenB, shortLenNow;
  logic             bLonger;
  logic [NUM_W-1:0] numInit;

  assign firstA      = lowestSet(liveA);
  assign firstB      = lowestSet(liveB);
  assign lenA        = LEN_W'($countones(liveA));
  assign lenB        = LEN_W'($countones(liveB));
  assign bLonger     = (lenB > lenA);
  assign shortLenNow = bLonger ? lenA : lenB;
  assign numInit     = NUM_W'(SCALE) * NUM_W'(shortLenNow);

  logic                    shortIsA;
  logic [LEN_W-1:0]        longLen;
  logic [LEN_W-1:0]        rem;
  logic [QUOT_W-1:0]       quot;
  logic [DCNT_W-1:0]       divCnt;
  logic signed [CNT_W-1:0] credit;
  logic [OUT_W-1:0]        wrNext;

  assign shortEmpty = shortIsA ? ~|liveA : ~|liveB;
  assign longEmpty  = shortIsA ? ~|liveB : ~|liveA;
  assign bothEmpty  = ~|liveA && ~|liveB;
  assign cntPos     = (credit > 0);
  assign divLast    = (divCnt == DCNT_W'(QUOT_W - 1));

  // Pop selection: which list gives up its lowest live entry this cycle.
  logic              takeA, takeB;
  logic [DATA_W-1:0] popValue;
  assign takeA    = (strb.popShort && shortIsA) || (strb.popLong && !shortIsA);
  assign takeB    = (strb.popShort && !shortIsA) || (strb.popLong && shortIsA);
  assign popValue = takeA ? listA[firstA] : listB[firstB];

  // Restoring divider step.
  logic [LEN_W:0] divShift;
  logic [LEN_W:0] divDiff;
  logic           divFits;
  assign divShift = {rem, quot[QUOT_W-1]};
  assign divFits  = (divShift >= {1'b0, longLen});
  assign divDiff  = divShift - {1'b0, longLen};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        listA[i] <= EMPTY;
        listB[i] <= EMPTY;
      end
    end else begin
      if (!busy && loadA) listA[loadIdx] <= loadData;
      if (!busy && loadB) listB[loadIdx] <= loadData;
      if (takeA) listA[firstA] <= EMPTY;
      if (takeB) listB[firstB] <= EMPTY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shortIsA <= 1'b0;
      longLen  <= '0;
      rem      <= '0;
      quot     <= '0;
      divCnt   <= '0;
      credit   <= '0;
      wrNext   <= '0;
      outWrEn  <= 1'b0;
      outIdx   <= '0;
      outData  <= '0;
    end else begin
      outWrEn <= strb.popShort || strb.popLong;
      if (strb.initRun) begin
        shortIsA <= bLonger;
        longLen  <= bLonger ? lenB : lenA;
        rem      <= numInit[NUM_W-1:QUOT_W];
        quot     <= numInit[QUOT_W-1:0];
        divCnt   <= '0;
        credit   <= '0;
        wrNext   <= '0;
      end
      if (strb.divStep) begin
        divCnt <= divCnt + 1'b1;
        if (divFits) begin
          rem  <= divDiff[LEN_W-1:0];
          quot <= {quot[QUOT_W-2:0], 1'b1};
        end else begin
          rem  <= divShift[LEN_W-1:0];
          quot <= {quot[QUOT_W-2:0], 1'b0};
        end
      end
      if (strb.popShort) credit <= credit + $signed(CNT_W'(SCALE));
      if (strb.popLong)  credit <= credit - $signed(CNT_W'(quot));
      if (strb.popShort || strb.popLong) begin
        outData <= popValue;
        outIdx  <= wrNext;
        wrNext  <= wrNext + 1'b1;
      end
    end
  end

endmodule

// File: rtl/interleave_merger_ctrl.sv
module interleave_merger_ctrl
  import interleave_merger_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          shortEmpty,
  input  logic          longEmpty,
  input  logic          bothEmpty,
  input  logic          cntPos,
  input  logic          divLast,
  output mergeStrobes_t strb,
  output logic          busy,
  output logic          done,
  output logic          error
);

  mergeState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE, ST_DONE, ST_ERR: begin
        if (start) begin
          strb.initRun = 1'b1;
          stateNext    = bothEmpty ? ST_DONE : ST_DIV;
        end
      end
      ST_DIV: begin
        strb.divStep = 1'b1;
        if (divLast) stateNext = ST_ROUND;
      end
      ST_ROUND: begin
        if (!shortEmpty) begin
          strb.popShort = 1'b1;
          stateNext     = ST_LONG;
        end else if (longEmpty) begin
          stateNext = ST_DONE;
        end else if (cntPos) begin
          stateNext = ST_LONG;
        end else begin
          stateNext = ST_ERR;
        end
      end
      ST_LONG: begin
        if (!longEmpty && cntPos) strb.popLong = 1'b1;
        else                      stateNext    = ST_ROUND;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy  = (state == ST_DIV) || (state == ST_ROUND) || (state == ST_LONG);
  assign done  = (state == ST_DONE) || (state == ST_ERR);
  assign error = (state == ST_ERR);

endmodule

// File: rtl/interleave_merger.sv
module interleave_merger
  import interleave_merger_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  parameter int SCALE  = 100000,
  parameter int QUOT_W = 17,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OUT_W = $clog2(2 * DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadA,
  input  logic              loadB,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [DATA_W-1:0] loadData,
  input  logic              start,
  output logic              outWrEn,
  output logic [OUT_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outData,
  output logic              done,
  output logic              error
);

  mergeStrobes_t strb;
  logic busy, shortEmpty, longEmpty, bothEmpty, cntPos, divLast;

  interleave_merger_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .shortEmpty (shortEmpty),
    .longEmpty  (longEmpty),
    .bothEmpty  (bothEmpty),
    .cntPos     (cntPos),
    .divLast    (divLast),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  interleave_merger_dp #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .SCALE  (SCALE),
    .QUOT_W (QUOT_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busy       (busy),
    .loadA      (loadA),
    .loadB      (loadB),
    .loadIdx    (loadIdx),
    .loadData   (loadData),
    .strb       (strb),
    .shortEmpty (shortEmpty),
    .longEmpty  (longEmpty),
    .bothEmpty  (bothEmpty),
    .cntPos     (cntPos),
    .divLast    (divLast),
    .outWrEn    (outWrEn),
    .outIdx     (outIdx),
    .outData    (outData)
  );

endmodule

// File: rtl/interleave_merger_chk.sv
module interleave_merger_chk #(
  parameter int OUT_W  = 7,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              outWrEn,
  input logic [OUT_W-1:0]  outIdx,
  input logic [DATA_W-1:0] outData,
  input logic              done,
  input logic              error
);

  logic [OUT_W-1:0] lastIdx;
  logic             seenWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastIdx <= '0;
      seenWr  <= 1'b0;
    end else if (outWrEn) begin
      lastIdx <= outIdx;
      seenWr  <= 1'b1;
    end
  end

  assert_no_marker_R1: assert property (@(posedge clk) disable iff (!rstN)
    outWrEn |-> (outData != '1));

  assert_error_has_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  assert_quiet_when_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outWrEn);

  assert_idx_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outWrEn && outIdx != '0) |-> (seenWr && outIdx == lastIdx + 1'b1));

  assert_hold_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(error)));

  assert_done_drops_on_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> $past(start));

endmodule

bind interleave_merger interleave_merger_chk #(
  .OUT_W  (OUT_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .outWrEn (outWrEn),
  .outIdx  (outIdx),
  .outData (outData),
  .done    (done),
  .error   (error)
);

// File: tb/interleave_merger_tb.sv
module interleave_merger_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TB_DEPTH   = 8;
  localparam int TB_IDX_W   = $clog2(TB_DEPTH);
  localparam int TB_OUT_W   = $clog2(2 * TB_DEPTH);

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                loadA = 1'b0, loadB = 1'b0;
  logic [TB_IDX_W-1:0] loadIdx = '0;
  logic [15:0]         loadData = '0;
  logic                start = 1'b0;
  logic                outWrEn;
  logic [TB_OUT_W-1:0] outIdx;
  logic [15:0]         outData;
  logic                done, error;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  int  mA [TB_DEPTH];
  int  mB [TB_DEPTH];
  int  expQ [2*TB_DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  interleave_merger #(.DEPTH(TB_DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .loadA(loadA), .loadB(loadB),
    .loadIdx(loadIdx), .loadData(loadData), .start(start),
    .outWrEn(outWrEn), .outIdx(outIdx), .outData(outData),
    .done(done), .error(error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int popModel(input bit useA);
    int v;
    v = -1;
    for (int p = 0; p < TB_DEPTH; p++) begin
      if (v < 0) begin
        if (useA && mA[p] >= 0)  begin v = mA[p]; mA[p] = -1; end
        if (!useA && mB[p] >= 0) begin v = mB[p]; mB[p] = -1; end
      end
    end
    return v;
  endfunction

  function automatic int lenModel(input bit useA);
    int n;
    n = 0;
    for (int p = 0; p < TB_DEPTH; p++) begin
      if (useA && mA[p] >= 0) n++;
      if (!useA && mB[p] >= 0) n++;
    end
    return n;
  endfunction

  // Reference merge: R3 selection, R4 score, R5 rounds, R6 stall.
  task automatic modelRun(output int expN, output bit expErr);
    int  la, lb, s, l, tgt;
    bit  shortA, act;
    longint cnt;
    expN = 0; expErr = 0;
    la = lenModel(1); lb = lenModel(0);
    shortA = (lb > la);
    s = shortA ? la : lb;
    l = shortA ? lb : la;
    if (l == 0) return;
    tgt = (100000 * s) / l;
    cnt = 0;
    while (lenModel(shortA) > 0 || lenModel(!shortA) > 0) begin
      act = 0;
      if (lenModel(shortA) > 0) begin
        expQ[expN] = popModel(shortA); expN++; cnt += 100000; act = 1;
      end
      while (lenModel(!shortA) > 0 && cnt > 0) begin
        expQ[expN] = popModel(!shortA); expN++; cnt -= tgt; act = 1;
      end
      if (!act) begin expErr = 1; break; end
    end
  endtask

  task automatic loadLists(input int nA, input int nB, input int rot);
    for (int p = 0; p < TB_DEPTH; p++) begin mA[p] = -1; mB[p] = -1; end
    for (int k = 0; k < nA; k++) begin
      int p = (k * 3 + rot) % TB_DEPTH;
      mA[p] = 'hA000 + p * 16 + k;
    end
    for (int k = 0; k < nB; k++) begin
      int p = (k * 5 + rot + 1) % TB_DEPTH;
      mB[p] = 'hB000 + p * 16 + k;
    end
    for (int p = 0; p < TB_DEPTH; p++) begin
      @(negedge clk);
      loadA = 1'b1; loadB = 1'b0; loadIdx = TB_IDX_W'(p);
      loadData = (mA[p] < 0) ? 16'hFFFF : 16'(mA[p]);
      @(negedge clk);
      loadA = 1'b0; loadB = 1'b1;
      loadData = (mB[p] < 0) ? 16'hFFFF : 16'(mB[p]);
    end
    @(negedge clk);
    loadA = 1'b0; loadB = 1'b0;
  endtask

  task automatic runAndCheck(input string tag);
    int expN, nWr, guard;
    bit expErr, errSeen;
    modelRun(expN, expErr);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    nWr = 0; guard = 0;
    while (!done && guard < 500) begin
      if (outWrEn) begin
        check(int'(outIdx) == nWr, {"R7 idx ", tag}, int'(outIdx), nWr);
        check(outData != 16'hFFFF, {"R1 marker out ", tag}, int'(outData), expQ[nWr]);
        check(int'(outData) == expQ[nWr], {"R3 R4 R5 order ", tag}, int'(outData), expQ[nWr]);
        nWr++;
      end
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, {"R6 done ", tag}, int'(done), 1);
    check(nWr == expN, {"R6 count ", tag}, nWr, expN);
    check(error == expErr, {"R6 error ", tag}, int'(error), int'(expErr));
    errSeen = error;
    repeat (3) @(negedge clk);
    check(done == 1'b1 && error == errSeen, {"R9 hold ", tag}, int'(error), int'(errSeen));
  endtask

  initial begin
    for (int p = 0; p < TB_DEPTH; p++) begin mA[p] = -1; mB[p] = -1; end
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R8 done after reset", int'(done), 0);
    check(error == 1'b0, "R8 error after reset", int'(error), 0);
    check(outWrEn == 1'b0, "R8 write after reset", int'(outWrEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R8 lists empty after reset; R10 empty start completes at once
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(done == 1'b1 && outWrEn == 1'b0, "R10 empty start done", int'(done), 1);
    check(error == 1'b0, "R10 empty start error", int'(error), 0);

    for (int rot = 0; rot < 2; rot++) begin
      for (int nA = 0; nA <= TB_DEPTH; nA++) begin
        for (int nB = 0; nB <= TB_DEPTH; nB++) begin
          loadLists(nA, nB, rot * 5);
          runAndCheck($sformatf("A%0d B%0d r%0d", nA, nB, rot));
          // R2: second start sees the lists as left by the popping
          runAndCheck($sformatf("R2 rerun A%0d B%0d r%0d", nA, nB, rot));
        end
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule